// File: doc/BRIEF.md
# Luma Active-Line Edge Shaper

This block tapers the luma samples at both ends of every active video line, so that a hard step from blanking into picture, or from picture back into blanking, is spread over three samples. The step becomes a short ramp, which reduces ringing in the analogue path downstream. When shaping is switched on, the opening three active samples of a line and the closing three are scaled down by fixed fractions. Every other sample, active or blanking, leaves the block unchanged. Chroma is not handled here.

Samples advance only on cycles where the pixel strobe is high. The closing ramp has to begin before the active flag falls, so the block holds three samples in a short delay line. This lets it look three samples ahead. The luma sample and the active flag come out together after a fixed delay of three strobes, whether shaping is on or off.

Top module: `luma_edge_shaper`

## Requirements
- R1: With `shape_on` low, every luma sample leaves the block unmodified.
- R2: A sample and its active flag, taken in with strobe k, appear on `luma_out`/`act_out` directly after strobe k+3. This holds whether shaping is on or off. Before three strobes have passed since reset, the outputs are zero and inactive.
- R3: On cycles without `pix_en`, both outputs hold their values, and the input pins have no effect on the sample sequence.
- R4: With shaping on, the first, second and third active samples of a line are output as x>>3, x>>1 and x−(x>>3), in that order (truncated).
- R5: With shaping on, the third-last, second-last and last active samples of a line are output as x−(x>>3), x>>1 and x>>3.
- R6: With shaping on, active samples more than two places from either end of the line pass unchanged.
- R7: In a line of fewer than six active samples, each sample takes the smaller of its opening and closing weights. The order from smallest to largest is 1/8, 1/2, 7/8, unity. Example outputs for a line of full-scale 1023: a 4-sample line gives 127, 511, 511, 127, and a 5-sample line gives 127, 511, 896, 511, 127.
- R8: Samples with the active flag low pass unchanged, even with shaping on.
- R9: With shaping on, an output sample never exceeds the input sample it came from.
- R10: While `rst_n` is low, the outputs stay at zero and inactive, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pix_en | input | 1 | Pixel strobe; the pipeline advances only when it is high |
| shape_on | input | 1 | Enables the edge ramps |
| act_in | input | 1 | Active-video flag of the incoming sample |
| luma_in | input | LUMA_W | Incoming luma sample |
| act_out | output | 1 | Active-video flag, delayed by three strobes |
| luma_out | output | LUMA_W | Shaped or passed luma, delayed by three strobes |

## Verification
The bench uses the default `LUMA_W` of 10. With this width, full-scale 1023 gives the ramp 127, 511, 896. A small value such as 9 separates the truncation rule x−(x>>3) = 8 from the rounding-down of 7x/8 = 7. At this width the bench can also send lines of one to six samples, separated by single blanking samples, and check every case where the opening and closing ramps overlap. Strobe gaps within a line then show that the look-ahead counts samples, not clock cycles.

// File: rtl/edge_shaper_pkg.sv
package edge_shaper_pkg;
  // Samples ramped at each end of an active line.
  localparam int RAMP_LEN = 3;

  // Ordered from smallest to largest weight, so a numeric min selects the smaller weight.
  typedef enum logic [1:0] {
    W_EIGHTH = 2'd0,
    W_HALF   = 2'd1,
    W_SEVEN8 = 2'd2,
    W_UNITY  = 2'd3
  } ramp_weight_e;

  function automatic ramp_weight_e weight_min(ramp_weight_e a, ramp_weight_e b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/edge_delay_line.sv
module edge_delay_line #(
  parameter int W     = 10,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [W-1:0]     luma_d,
  input  logic             act_d,
  output logic [W-1:0]     luma_old,
  output logic [DEPTH-1:0] act_tap
);
  logic [W-1:0] luma_st [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] luma_src;
    logic         act_src;
    if (g == 0) begin : g_head
      assign luma_src = luma_d;
      assign act_src  = act_d;
    end else begin : g_body
      assign luma_src = luma_st[g-1];
      assign act_src  = act_tap[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        luma_st[g] <= '0;
        act_tap[g] <= 1'b0;
      end else if (adv) begin
        luma_st[g] <= luma_src;
        act_tap[g] <= act_src;
      end
    end
  end

  assign luma_old = luma_st[DEPTH-1];
endmodule

// File: rtl/edge_weight_sel.sv
module edge_weight_sel
  import edge_shaper_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                cur_act,
  input  logic [RAMP_LEN-1:0] ahead_act,   // [0] is the nearest following sample
  output ramp_weight_e        head_w,
  output ramp_weight_e        tail_w,
  output ramp_weight_e        wsel
);
  ramp_weight_e head_q;
  logic         prev_act;

  // Weight from the distance to the line start, saturating at unity.
  always_comb begin
    if (!cur_act || !prev_act) head_w = W_EIGHTH;
    else if (head_q == W_UNITY) head_w = W_UNITY;
    else head_w = ramp_weight_e'(head_q + 2'd1);
  end

  // Weight from the distance to the first inactive sample ahead.
  always_comb begin
    tail_w = W_UNITY;
    for (int i = RAMP_LEN - 1; i >= 0; i--) begin
      if (!ahead_act[i]) tail_w = ramp_weight_e'(2'(i));
    end
  end

  assign wsel = weight_min(head_w, tail_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= W_EIGHTH;
      prev_act <= 1'b0;
    end else if (adv) begin
      head_q   <= head_w;
      prev_act <= cur_act;
    end
  end
endmodule

// File: rtl/edge_scaler.sv
module edge_scaler
  import edge_shaper_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] x,
  input  ramp_weight_e w,
  output logic [W-1:0] y
);
  function automatic logic [W-1:0] ramp_scale(logic [W-1:0] v, ramp_weight_e k);
    case (k)
      W_EIGHTH: return v >> 3;
      W_HALF:   return v >> 1;
      W_SEVEN8: return v - (v >> 3);
      default:  return v;
    endcase
  endfunction

  assign y = ramp_scale(x, w);
endmodule

// File: rtl/luma_edge_shaper.sv
module luma_edge_shaper
  import edge_shaper_pkg::*;
#(
  parameter int LUMA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              shape_on,
  input  logic              act_in,
  input  logic [LUMA_W-1:0] luma_in,
  output logic              act_out,
  output logic [LUMA_W-1:0] luma_out
);
  localparam int DEPTH = RAMP_LEN;

  logic [LUMA_W-1:0] tap_luma;
  logic [DEPTH-1:0]  act_tap;
  logic              tap_act;
  logic [DEPTH-1:0]  ahead_act;
  ramp_weight_e      head_w, tail_w, wsel;
  logic [LUMA_W-1:0] shaped;
  logic [LUMA_W-1:0] luma_nxt;

  edge_delay_line #(.W(LUMA_W), .DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_n), .adv(pix_en),
    .luma_d(luma_in), .act_d(act_in),
    .luma_old(tap_luma), .act_tap(act_tap)
  );

  assign tap_act = act_tap[DEPTH-1];

  // The look-ahead runs from the nearest delayed sample out to the live input.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ahead
    if (i < DEPTH - 1) begin : g_tap
      assign ahead_act[i] = act_tap[DEPTH-2-i];
    end else begin : g_live
      assign ahead_act[i] = act_in;
    end
  end

  edge_weight_sel u_wsel (
    .clk(clk), .rst_n(rst_n), .adv(pix_en),
    .cur_act(tap_act), .ahead_act(ahead_act),
    .head_w(head_w), .tail_w(tail_w), .wsel(wsel)
  );

  edge_scaler #(.W(LUMA_W)) u_scl (.x(tap_luma), .w(wsel), .y(shaped));

  assign luma_nxt = (shape_on && tap_act) ? shaped : tap_luma;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      luma_out <= '0;
      act_out  <= 1'b0;
    end else if (pix_en) begin
      luma_out <= luma_nxt;
      act_out  <= tap_act;
    end
  end
endmodule

// File: rtl/luma_edge_shaper_chk.sv
module luma_edge_shaper_chk
  import edge_shaper_pkg::*;
#(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pix_en,
  input logic         shape_on,
  input logic [W-1:0] tap_luma,
  input logic         tap_act,
  input logic         near_act,
  input ramp_weight_e wsel,
  input logic         act_out,
  input logic [W-1:0] luma_out
);
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !shape_on) |=> (luma_out == $past(tap_luma)));

  a_r2_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> (act_out == $past(tap_act)));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(luma_out) && $stable(act_out)));

  a_r4_first_eighth: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && shape_on && tap_act && !act_out) |=> (luma_out == ($past(tap_luma) >> 3)));

  a_r5_last_eighth: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && shape_on && tap_act && !near_act) |=> (luma_out == ($past(tap_luma) >> 3)));

  a_r6_mid_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && shape_on && tap_act && wsel == W_UNITY) |=> (luma_out == $past(tap_luma)));

  a_r8_blank_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !tap_act) |=> (luma_out == $past(tap_luma)));

  a_r9_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> (luma_out <= $past(tap_luma)));
endmodule

bind luma_edge_shaper luma_edge_shaper_chk #(.W(LUMA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .shape_on(shape_on),
  .tap_luma(tap_luma), .tap_act(tap_act), .near_act(ahead_act[0]),
  .wsel(wsel), .act_out(act_out), .luma_out(luma_out)
);

// File: tb/test_luma_edge_shaper.sv
`timescale 1ns/100ps
module test_luma_edge_shaper;
  localparam int W    = 10;
  localparam int MAXN = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pix_en = 1'b0;
  logic         shape_on = 1'b0;
  logic         act_in = 1'b0;
  logic [W-1:0] luma_in = '0;
  logic         act_out;
  logic [W-1:0] luma_out;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] s_luma [MAXN];
  bit           s_act  [MAXN];
  int           s_n = 0;

  luma_edge_shaper #(.LUMA_W(W)) i_luma_edge_shaper (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .shape_on(shape_on),
    .act_in(act_in), .luma_in(luma_in), .act_out(act_out), .luma_out(luma_out)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic clear_stream();
    s_n = 0;
  endtask

  task automatic put(int v, bit a);
    s_luma[s_n] = W'(v);
    s_act[s_n]  = a;
    s_n++;
  endtask

  task automatic put_line(int len, int v0, int v1);
    for (int i = 0; i < len; i++) put((i % 2 == 0) ? v0 : v1, 1'b1);
  endtask

  // Span of the active run holding sample j.
  function automatic int run_first(int j);
    int s = j;
    while (s > 0 && s_act[s-1]) s--;
    return s;
  endfunction

  function automatic int run_last(int j);
    int e = j;
    while (e < s_n - 1 && s_act[e+1]) e++;
    return e;
  endfunction

  function automatic int ref_out(int j, bit en);
    int p, q, c, x;
    x = int'(s_luma[j]);
    if (!en || !s_act[j]) return x;
    p = j - run_first(j);
    q = run_last(j) - j;
    c = (p < q) ? p : q;
    if (c == 0) return x / 8;
    if (c == 1) return x / 2;
    if (c == 2) return x - x / 8;
    return x;
  endfunction

  function automatic string req_tag(int j, bit en);
    int p, q;
    if (!en) return "R1";
    if (!s_act[j]) return "R8";
    p = j - run_first(j);
    q = run_last(j) - j;
    if (p + q + 1 < 6) return "R7";
    if (p < 3) return "R4";
    if (q < 3) return "R5";
    return "R6";
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    pix_en = 1'b1; act_in = 1'b1; luma_in = '1;
    repeat (3) @(negedge clk);
    chk("R10", "luma_out in reset", 32'(luma_out), 0);
    chk("R10", "act_out in reset", 32'(act_out), 0);
    pix_en = 1'b0; act_in = 1'b0; luma_in = '0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_stream(bit en, bit stalls);
    logic [W-1:0] held_l;
    logic         held_a;
    for (int i = 0; i < 3; i++) put(0, 1'b0);  // flush trailing samples out
    do_reset();
    shape_on = en;
    for (int k = 0; k < s_n; k++) begin
      pix_en = 1'b1; luma_in = s_luma[k]; act_in = s_act[k];
      @(negedge clk);
      if (k < 3) begin
        chk("R2", "luma before fill", 32'(luma_out), 0);
        chk("R2", "act before fill", 32'(act_out), 0);
      end else begin
        chk(req_tag(k - 3, en), $sformatf("luma of sample %0d", k - 3),
            32'(luma_out), 32'(ref_out(k - 3, en)));
        chk("R2", $sformatf("act of sample %0d", k - 3), 32'(act_out), 32'(s_act[k-3]));
        if (en) chk("R9", "no growth", 32'(luma_out > s_luma[k-3]), 0);
      end
      if (stalls && (k % 3 == 1)) begin
        held_l = luma_out; held_a = act_out;
        pix_en = 1'b0; luma_in = ~s_luma[k]; act_in = ~s_act[k];
        repeat (2) begin
          @(negedge clk);
          chk("R3", "luma held", 32'(luma_out), 32'(held_l));
          chk("R3", "act held", 32'(act_out), 32'(held_a));
        end
      end
    end
    pix_en = 1'b0; act_in = 1'b0; luma_in = '0;
  endtask

  task automatic t_bypass();
    clear_stream();
    put(300, 1'b0); put(301, 1'b0);
    put_line(8, 1023, 9);
    put(5, 1'b0);
    put_line(2, 9, 1023);
    run_stream(1'b0, 1'b0);
  endtask

  task automatic t_long_line();
    clear_stream();
    put(0, 1'b0); put(0, 1'b0);
    put(1023, 1'b1); put(9, 1'b1); put(800, 1'b1); put(17, 1'b1); put(512, 1'b1);
    put(513, 1'b1); put(1000, 1'b1); put(9, 1'b1); put(64, 1'b1); put(1023, 1'b1);
    run_stream(1'b1, 1'b0);
  endtask

  task automatic t_short_lines();
    clear_stream();
    put(0, 1'b0);
    for (int len = 1; len <= 6; len++) begin
      put_line(len, 1023, 9);
      put(0, 1'b0);
    end
    run_stream(1'b1, 1'b0);
  endtask

  task automatic t_stalls();
    clear_stream();
    put(0, 1'b0);
    put_line(8, 1023, 9);
    put(0, 1'b0);
    put_line(4, 1023, 1023);
    run_stream(1'b1, 1'b1);
  endtask

  task automatic t_blanking();
    clear_stream();
    put(1023, 1'b0); put(700, 1'b0); put(9, 1'b0);
    put_line(7, 1023, 9);
    put(555, 1'b0); put(1023, 1'b0);
    run_stream(1'b1, 1'b0);
  endtask

  initial begin
    t_bypass();
    t_long_line();
    t_short_lines();
    t_stalls();
    t_blanking();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule